// File: doc/BRIEF.md
# High-Side Switch Diagnostic Controller

This block supervises a single-channel high-side power switch. It takes a logic on/off command, a pin that silences the diagnostic status, and six digitized comparator flags from the analog front end. These flags report light load current, output voltage above the off-state threshold, junction over the shutdown temperature, junction under the restart temperature, junction under the status-clear temperature, and supply undervoltage. From these inputs it drives the gate enable and an open-drain status line. The status line is modelled as a pull-low request plus a high-impedance flag.

Every fault is qualified by its own delay, counted in clock ticks. Some delays are measured from the falling edge of the command. The thermal protection keeps two latches. The first decides when the gate may switch on again. The second decides, at a lower temperature, when the status indication is withdrawn. Only the highest-priority active condition drives the status, in this order: undervoltage, then thermal, then load faults, then normal.

Top module: `hss_diag_ctrl`

## Requirements
- R1: While the synchronized status-disable input is 1, `stat_hiz_o` is 1 and `stat_pull_o` is 0, whatever faults are present.
- R2: With no fault present, `gate_en_o` follows the command and `stat_pull_o` is 0.
- R3: Once the over-temperature flag is seen, the gate is forced off on the following cycle. The status pull is asserted T_OT ticks after the flag appears, and only while the command is 1.
- R4: The gate may turn on again once the restart-temperature flag is 1. The thermal status pull stays asserted until the status-clear-temperature flag is 1.
- R5: With the command at 1 and the light-load flag at 1 for T_OLON consecutive ticks, the status is pulled low.
- R6: When the command falls while an on-state open load is reported, the pull stays asserted for T_POL ticks and is then released.
- R7: With the command at 0 and the output-high flag at 1 for T_STK ticks from the falling edge, the status is pulled low. With the command at 1, the output-high flag does not pull the status.
- R8: Undervoltage forces the gate off and the status released (pull 0), whatever the command or other faults. The block resumes normal reporting once the flag clears.
- R9: A qualifying condition that drops before its delay expires restarts that delay, so shorter glitches never change the status.
- R10: When a thermal fault and a load fault are active together, the thermal rule alone sets the status.
- R11: Every input passes through a two-flop synchronizer, and the outputs are registered. A command change reaches `gate_en_o` after the third rising clock edge.
- R12: Under reset, the gate is off, the status is released, and all counters and latches are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 1 | On/off command |
| stat_dis_i | input | 1 | 1 = status line high impedance |
| load_low_i | input | 1 | Load current below open-load threshold |
| vout_high_i | input | 1 | Output voltage above off-state threshold |
| tj_over_i | input | 1 | Junction above shutdown temperature |
| tj_restart_i | input | 1 | Junction below restart temperature |
| tj_sclr_i | input | 1 | Junction below status-clear temperature |
| uv_i | input | 1 | Supply undervoltage |
| gate_en_o | output | 1 | Power stage gate enable |
| stat_pull_o | output | 1 | Request to pull status line low |
| stat_hiz_o | output | 1 | Status line high impedance |

## Verification
A thermal fault can be active in the same cycle as a stuck-output load fault. The bench provokes this by holding the over-temperature flag with the command low, then raising the output-high flag for longer than its delay, so that both qualifiers are live together. Because the command is low, the thermal rule demands a released status while the load rule demands a pull. The bench therefore judges priority by expecting the status to stay released. It makes the same kind of check under undervoltage combined with an on-state open load.

// File: rtl/hss_pkg.sv
package hss_pkg;
  typedef struct packed {
    logic stat_dis;
    logic cmd;
    logic load_low;
    logic vout_high;
    logic tj_over;
    logic tj_restart;
    logic tj_sclr;
    logic uv;
  } hss_flags_t;

  localparam int unsigned FLAG_W = $bits(hss_flags_t);

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_THERM = 2'd2,
    ACT_UV    = 2'd3
  } hss_act_e;
endpackage

// File: rtl/hss_sync.sv
module hss_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/hss_qual_dly.sv
module hss_qual_dly #(
  parameter int unsigned TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  output logic done_o
);
  localparam int unsigned CW = (TICKS < 2) ? 1 : $clog2(TICKS);
  localparam logic [CW-1:0] RELOAD = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= RELOAD;
    else if (!cond_i)         cnt_q <= RELOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = cond_i && (cnt_q == '0);

  // a dropped condition restarts the wait
  assert_dly_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cond_i && TICKS > 1) |=> !done_o);
endmodule

// File: rtl/hss_thermal.sv
module hss_thermal #(
  parameter int unsigned T_OT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic over_i,
  input  logic restart_i,
  input  logic sclr_i,
  output logic hold_o,
  output logic stat_o
);
  logic over_done;

  hss_qual_dly #(.TICKS(T_OT)) u_ot_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cond_i(over_i),
    .done_o(over_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= 1'b0;
      stat_o <= 1'b0;
    end else begin
      if (over_i)                 hold_o <= 1'b1;
      else if (restart_i)         hold_o <= 1'b0;
      if (over_done)              stat_o <= 1'b1;
      else if (sclr_i)            stat_o <= 1'b0;
    end
  end

  assert_stat_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o && !sclr_i) |=> stat_o);
endmodule

// File: rtl/hss_diag_ctrl.sv
module hss_diag_ctrl
  import hss_pkg::*;
#(
  parameter int unsigned T_OT   = 5000,
  parameter int unsigned T_OLON = 50000,
  parameter int unsigned T_POL  = 187500,
  parameter int unsigned T_STK  = 45000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  input  logic stat_dis_i,
  input  logic load_low_i,
  input  logic vout_high_i,
  input  logic tj_over_i,
  input  logic tj_restart_i,
  input  logic tj_sclr_i,
  input  logic uv_i,
  output logic gate_en_o,
  output logic stat_pull_o,
  output logic stat_hiz_o
);
  localparam int unsigned POL_W = (T_POL < 2) ? 1 : $clog2(T_POL);
  localparam logic [POL_W-1:0] POL_LOAD = POL_W'(T_POL - 1);

  hss_flags_t raw, s;
  logic [FLAG_W-1:0] s_vec;

  assign raw = '{stat_dis: stat_dis_i, cmd: cmd_i, load_low: load_low_i,
                 vout_high: vout_high_i, tj_over: tj_over_i,
                 tj_restart: tj_restart_i, tj_sclr: tj_sclr_i, uv: uv_i};

  hss_sync #(.WIDTH(FLAG_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (s_vec)
  );
  assign s = hss_flags_t'(s_vec);

  logic therm_hold, therm_stat;
  hss_thermal #(.T_OT(T_OT)) u_therm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .over_i   (s.tj_over),
    .restart_i(s.tj_restart),
    .sclr_i   (s.tj_sclr),
    .hold_o   (therm_hold),
    .stat_o   (therm_stat)
  );

  logic olon_done, stk_done;
  hss_qual_dly #(.TICKS(T_OLON)) u_olon_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cond_i(s.cmd && s.load_low),
    .done_o(olon_done)
  );
  hss_qual_dly #(.TICKS(T_STK)) u_stk_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cond_i(!s.cmd && s.vout_high),
    .done_o(stk_done)
  );

  // off-state tail of an on-state open load
  logic             cmd_d, olon_q, cmd_fall;
  logic [POL_W-1:0] pol_cnt;
  logic             pol_pull;

  assign cmd_fall = cmd_d && !s.cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_d   <= 1'b0;
      olon_q  <= 1'b0;
      pol_cnt <= '0;
    end else begin
      cmd_d  <= s.cmd;
      olon_q <= olon_done;
      if (cmd_fall && olon_q)   pol_cnt <= POL_LOAD;
      else if (s.cmd)           pol_cnt <= '0;
      else if (pol_cnt != '0)   pol_cnt <= pol_cnt - 1'b1;
    end
  end

  assign pol_pull = (pol_cnt != '0) || (cmd_fall && olon_q);

  hss_act_e act;
  logic     pull_d, gate_d;

  always_comb begin
    if (s.uv)                               act = ACT_UV;
    else if (therm_hold || therm_stat)      act = ACT_THERM;
    else if (olon_done || pol_pull || stk_done) act = ACT_LOAD;
    else                                    act = ACT_NONE;
  end

  always_comb begin
    unique case (act)
      ACT_UV:    pull_d = 1'b0;
      ACT_THERM: pull_d = s.cmd && therm_stat;
      ACT_LOAD:  pull_d = 1'b1;
      default:   pull_d = 1'b0;
    endcase
    gate_d = s.cmd && !s.uv && !therm_hold;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_en_o   <= 1'b0;
      stat_pull_o <= 1'b0;
      stat_hiz_o  <= 1'b0;
    end else begin
      gate_en_o   <= gate_d;
      stat_pull_o <= pull_d && !s.stat_dis;
      stat_hiz_o  <= s.stat_dis;
    end
  end

  assert_hiz_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_hiz_o |-> !stat_pull_o);
  assert_ot_gate_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_hold |=> !gate_en_o);
  assert_uv_gate_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s.uv |=> !gate_en_o);
  assert_uv_no_pull_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s.uv |=> !stat_pull_o);
  assert_therm_cmd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_hold && !s.cmd && !s.uv) |=> !stat_pull_o);
endmodule

// File: tb/hss_diag_ctrl_test.sv
module hss_diag_ctrl_test;
  localparam int unsigned T_OT = 8, T_OLON = 20, T_POL = 40, T_STK = 30;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd = 0, sdis = 0, lowl = 0, vhi = 0, tov = 0, trs = 1, tsc = 1, uv = 0;
  logic gate, pull, hiz;

  always #2 clk = ~clk;

  hss_diag_ctrl #(.T_OT(T_OT), .T_OLON(T_OLON), .T_POL(T_POL), .T_STK(T_STK)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd), .stat_dis_i(sdis),
    .load_low_i(lowl), .vout_high_i(vhi), .tj_over_i(tov),
    .tj_restart_i(trs), .tj_sclr_i(tsc), .uv_i(uv),
    .gate_en_o(gate), .stat_pull_o(pull), .stat_hiz_o(hiz));

  typedef struct {
    logic  g, p, h;
    string tag;
  } exp_t;
  exp_t exp_q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic g, input logic p, input logic h);
    exp_t e;
    e.g = g; e.p = p; e.h = h; e.tag = tag;
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if ({gate, pull, hiz} !== {e.g, e.p, e.h}) begin
        errors++;
        $display("FAIL %s: gate/pull/hiz got %b%b%b exp %b%b%b",
                 e.tag, gate, pull, hiz, e.g, e.p, e.h);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung exp done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    expect_out("R12 reset", 0, 0, 0);
    step(1);
    rst_ni = 1'b1;
    step(2);
    // R11 latency
    cmd = 1;
    step(2); expect_out("R11 not yet", 0, 0, 0);
    step(1); expect_out("R11/R2 on", 1, 0, 0);
    cmd = 0;
    step(3); expect_out("R2 off", 0, 0, 0);
    // R1 status disable with open load
    sdis = 1; cmd = 1; lowl = 1;
    step(T_OLON + 6); expect_out("R1 hiz", 1, 0, 1);
    sdis = 0;
    step(3); expect_out("R1 reenable", 1, 1, 0);
    lowl = 0; step(5); cmd = 0; step(5);
    expect_out("R2 idle", 0, 0, 0);
    // R5 on-state open load
    cmd = 1; lowl = 1;
    step(T_OLON - 3); expect_out("R5 before", 1, 0, 0);
    step(8); expect_out("R5 after", 1, 1, 0);
    // R6 off-state tail
    cmd = 0;
    step(3); expect_out("R6 hold", 0, 1, 0);
    step(T_POL - 8); expect_out("R6 still", 0, 1, 0);
    step(12); expect_out("R6 release", 0, 0, 0);
    lowl = 0; step(3);
    // R9 glitches
    cmd = 1;
    for (int i = 0; i < 5; i++) begin
      lowl = 1; step(T_OLON / 2);
      lowl = 0; step(2);
    end
    step(3); expect_out("R9 glitch", 1, 0, 0);
    // R7 stuck output
    vhi = 1;
    step(T_STK + 6); expect_out("R7 cmd high", 1, 0, 0);
    cmd = 0;
    step(T_STK - 2); expect_out("R7 before", 0, 0, 0);
    step(6); expect_out("R7 after", 0, 1, 0);
    vhi = 0;
    step(3); expect_out("R7 clear", 0, 0, 0);
    // R3 overtemperature
    cmd = 1; step(5);
    tov = 1; trs = 0; tsc = 0;
    step(5); expect_out("R3 gate off", 0, 0, 0);
    step(T_OT + 4); expect_out("R3 pull", 0, 1, 0);
    cmd = 0;
    step(3); expect_out("R3 cmd low", 0, 0, 0);
    // R10 thermal over stuck output
    vhi = 1;
    step(T_STK + 6); expect_out("R10 priority", 0, 0, 0);
    vhi = 0; cmd = 1;
    step(3); expect_out("R3 cmd high", 0, 1, 0);
    // R4 restart then status clear
    tov = 0;
    step(5); expect_out("R4 still off", 0, 1, 0);
    trs = 1;
    step(5); expect_out("R4 restart", 1, 1, 0);
    tsc = 1;
    step(5); expect_out("R4 clear", 1, 0, 0);
    // R8 undervoltage with open load
    uv = 1; lowl = 1;
    step(3); expect_out("R8 uv", 0, 0, 0);
    step(T_OLON + 6); expect_out("R8 uv prio", 0, 0, 0);
    uv = 0;
    step(3); expect_out("R8 resume", 1, 1, 0);
    step(2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule